// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block runs one temperature measurement on an external power-management device whose registers are reached through a byte-wide request/acknowledge register port. A serial-bus master that turns each request into a real bus transfer sits outside the block. After a host start with a non-zero channel code, the sequencer powers up the converter and selects the channel. It waits a fixed settling interval and then launches the conversion. The converter's interrupt is opened only for as long as the conversion runs. The sequencer then reads the 10-bit result and powers the converter down again. Every change to a shared register is a read-modify-write, so the other bits in that register are kept.

Completion comes from a level interrupt line from the device. When the line is high, the sequencer reads the interrupt status byte and writes the same byte back to clear it. Only the converter bit ends the wait. If that bit does not show up within the timeout, a timeout flag is raised, but the interrupt is still masked again and the converter is still powered down. A bus error response aborts the sequence at once. The raw code and the two flags stay valid until the next start.

Top module: `thermConvSeq`

## Requirements
- R1: After reset `busy`, `done`, `busValid`, `errFlag` and `timeoutFlag` are all low.
- R2: Once `busValid` is raised, it stays high, and `busAddr`, `busWrite` and `busWdata` stay unchanged, until the cycle in which `busReady` is high.
- R3: Power-up order on control byte 0x50 (bit 5 enable, bits 2:1 channel, bit 0 start). First a read of 0x50 giving value C. Then a write of C|0x20. Then a write of C|0x20|(ch<<1). Then a write of C|0x21|(ch<<1).
- R4: At least SETTLE_CYC = CLK_HZ/1e6*SETTLE_US clock cycles pass between the acknowledge of the channel write and the request of the start write.
- R5: After the start write, mask byte 0x02 is read and written back with bit 2 cleared. All other bits keep their values.
- R6: While `devIrq` is high in the wait, status byte 0x01 is read and the same value is written back. The wait ends only if bit 2 of that value is set; otherwise the wait goes on.
- R7: If bit 2 is not seen within TIMEOUT_CYC = CLK_HZ/1000*TIMEOUT_MS cycles after the unmask write, `timeoutFlag` is set and the remaining steps still run.
- R8: After the wait, mask byte 0x02 is read and written back with bit 2 set. All other bits keep their values.
- R9: The result bytes are read high first, then low, from 0x56/0x57 (ch 1), 0x58/0x59 (ch 2) or 0x5A/0x5B (ch 3). `rawCode` = {high[1:0], low}.
- R10: Finally 0x50 is read again and written back with bits 5, 2 and 1 cleared. All other bits are kept as read.
- R11: `busy` is high from the cycle after an accepted start until the sequence ends. `done` is then high for one cycle, with `busy` low.
- R12: A `busErr` together with `busReady` ends the sequence. `errFlag` is set, `done` pulses and no further request is made.
- R13: A start with channel code 0 makes no bus request and returns `done` with `errFlag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Host start pulse, taken when idle |
| chanSel | input | 2 | Channel code (1, 2 or 3) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rawCode | output | 10 | Assembled conversion result |
| errFlag | output | 1 | Last sequence aborted or rejected |
| timeoutFlag | output | 1 | Last conversion did not complete in time |
| busValid | output | 1 | Register request pending |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 8 | Register address |
| busWdata | output | 8 | Write data |
| busReady | input | 1 | Request accepted and finished |
| busRdata | input | 8 | Read data, valid with busReady |
| busErr | input | 1 | Error response, valid with busReady |
| devIrq | input | 1 | Device interrupt line, active high |

## Verification
A wrong state or a lost captured byte shows up at the register port within one transaction. A missing or extra access appears there, or a write carries a byte that differs from the byte read just before it. A bad settle or timeout count shows as a gap that is too short between particular acknowledge and request cycles. A wrong channel latch shows as the wrong result address, and a wrong result assembly shows in `rawCode` on the `done` cycle. A stuck wait would hold `busy` until the run limit, so every run is also bounded by the expected sequence length.

// File: rtl/thermSeqPkg.sv
package thermSeqPkg;
  localparam logic [7:0] ADDR_STAT    = 8'h01;
  localparam logic [7:0] ADDR_MASK    = 8'h02;
  localparam logic [7:0] ADDR_CTRL    = 8'h50;
  localparam logic [7:0] ADDR_RESBASE = 8'h56;
  localparam int BIT_GO     = 0;
  localparam int BIT_PWR    = 5;
  localparam int BIT_ADCIRQ = 2;
  localparam logic [7:0] CHAN_FIELD = 8'h06;

  typedef enum logic [3:0] {
    OP_NONE, OP_RD_CTRL, OP_WR_EN, OP_WR_CHAN, OP_WR_GO, OP_RD_MASK,
    OP_WR_UNMASK, OP_RD_STAT, OP_WR_STAT, OP_WR_MASK, OP_RD_HI, OP_RD_LO,
    OP_WR_OFF
  } busOpT;

  typedef struct packed {
    busOpT op;
    logic  cntClr;
    logic  arm;
  } dpCtlT;
endpackage

// File: rtl/thermSeqDatapath.sv
module thermSeqDatapath
  import thermSeqPkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 5000,
  parameter int unsigned TIMEOUT_CYC = 100000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtlT       ctl,
  input  logic [1:0]  chanIn,
  input  logic        busAck,
  input  logic [7:0]  busRdata,
  output logic [7:0]  busAddr,
  output logic [7:0]  busWdata,
  output logic        busWrite,
  output logic        settleDone,
  output logic        timeoutHit,
  output logic        adcStatHit,
  output logic [9:0]  rawCode
);
  localparam int unsigned CNT_MAX = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);

  logic [1:0]    chan;
  logic [7:0]    ctrlByte, maskByte, statByte, loByte;
  logic [1:0]    hiBits;
  logic [CW-1:0] cnt;
  logic [7:0]    resHiAddr;
  logic [7:0]    ctrlOn;

  assign resHiAddr = ADDR_RESBASE + {5'd0, chan - 2'd1, 1'b0};
  assign ctrlOn    = ctrlByte | (8'd1 << BIT_PWR);

  always_comb begin
    busAddr  = ADDR_CTRL;
    busWdata = 8'h00;
    busWrite = 1'b0;
    unique case (ctl.op)
      OP_WR_EN:     begin busWrite = 1'b1; busWdata = ctrlOn; end
      OP_WR_CHAN:   begin busWrite = 1'b1; busWdata = ctrlOn | {5'd0, chan, 1'b0}; end
      OP_WR_GO:     begin busWrite = 1'b1;
                          busWdata = ctrlOn | {5'd0, chan, 1'b0} | (8'd1 << BIT_GO); end
      OP_WR_OFF:    begin busWrite = 1'b1;
                          busWdata = ctrlByte & ~((8'd1 << BIT_PWR) | CHAN_FIELD); end
      OP_RD_MASK:   busAddr = ADDR_MASK;
      OP_WR_UNMASK: begin busAddr = ADDR_MASK; busWrite = 1'b1;
                          busWdata = maskByte & ~(8'd1 << BIT_ADCIRQ); end
      OP_WR_MASK:   begin busAddr = ADDR_MASK; busWrite = 1'b1;
                          busWdata = maskByte | (8'd1 << BIT_ADCIRQ); end
      OP_RD_STAT:   busAddr = ADDR_STAT;
      OP_WR_STAT:   begin busAddr = ADDR_STAT; busWrite = 1'b1; busWdata = statByte; end
      OP_RD_HI:     busAddr = resHiAddr;
      OP_RD_LO:     busAddr = resHiAddr + 8'd1;
      default:      ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chan     <= 2'd0;
      ctrlByte <= 8'h00;
      maskByte <= 8'h00;
      statByte <= 8'h00;
      hiBits   <= 2'd0;
      loByte   <= 8'h00;
    end else begin
      if (ctl.arm) begin
        chan   <= chanIn;
        hiBits <= 2'd0;
        loByte <= 8'h00;
      end
      if (busAck) begin
        unique case (ctl.op)
          OP_RD_CTRL: ctrlByte <= busRdata;
          OP_RD_MASK: maskByte <= busRdata;
          OP_RD_STAT: statByte <= busRdata;
          OP_RD_HI:   hiBits   <= busRdata[1:0];
          OP_RD_LO:   loByte   <= busRdata;
          default:    ;
        endcase
      end
    end
  end

  // Shared interval counter: cleared by control, saturates at its maximum.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (ctl.cntClr)               cnt <= '0;
    else if (cnt != CW'(CNT_MAX))      cnt <= cnt + 1'b1;
  end

  assign settleDone = (cnt >= CW'(SETTLE_CYC));
  assign timeoutHit = (cnt >= CW'(TIMEOUT_CYC));
  assign adcStatHit = statByte[BIT_ADCIRQ];
  assign rawCode    = {hiBits, loByte};

  // R13: no register access is ever issued for channel code 0
  assert_chan_nonzero_R13: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.op != OP_NONE && !ctl.arm) |-> (chan != 2'd0));
endmodule

// File: rtl/thermSeqControl.sv
module thermSeqControl
  import thermSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] chanSel,
  input  logic       busReady,
  input  logic       busErr,
  input  logic       devIrq,
  input  logic       settleDone,
  input  logic       timeoutHit,
  input  logic       adcStatHit,
  output dpCtlT      ctl,
  output logic       busValid,
  output logic       busy,
  output logic       done,
  output logic       errFlag,
  output logic       timeoutFlag
);
  typedef enum logic [4:0] {
    S_IDLE, S_RD_CTRL0, S_WR_EN, S_WR_CHAN, S_SETTLE, S_WR_GO, S_RD_MASK0,
    S_WR_UNMASK, S_WAIT, S_RD_STAT, S_WR_STAT, S_RD_MASK1, S_WR_MASK,
    S_RD_HI, S_RD_LO, S_RD_CTRL1, S_WR_OFF
  } stateT;

  stateT state, nextState;
  logic  busAck;

  always_comb begin
    ctl.op = OP_NONE;
    unique case (state)
      S_RD_CTRL0, S_RD_CTRL1: ctl.op = OP_RD_CTRL;
      S_WR_EN:                ctl.op = OP_WR_EN;
      S_WR_CHAN:              ctl.op = OP_WR_CHAN;
      S_WR_GO:                ctl.op = OP_WR_GO;
      S_RD_MASK0, S_RD_MASK1: ctl.op = OP_RD_MASK;
      S_WR_UNMASK:            ctl.op = OP_WR_UNMASK;
      S_RD_STAT:              ctl.op = OP_RD_STAT;
      S_WR_STAT:              ctl.op = OP_WR_STAT;
      S_WR_MASK:              ctl.op = OP_WR_MASK;
      S_RD_HI:                ctl.op = OP_RD_HI;
      S_RD_LO:                ctl.op = OP_RD_LO;
      S_WR_OFF:               ctl.op = OP_WR_OFF;
      default:                ;
    endcase
  end

  assign busValid   = (ctl.op != OP_NONE);
  assign busAck     = busValid && busReady;
  assign ctl.arm    = (state == S_IDLE) && startReq && (chanSel != 2'd0);
  assign ctl.cntClr = busAck && (state == S_WR_CHAN || state == S_WR_UNMASK);
  assign busy       = (state != S_IDLE);

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:      if (ctl.arm) nextState = S_RD_CTRL0;
      S_SETTLE:    if (settleDone) nextState = S_WR_GO;
      S_WAIT:      if (devIrq) nextState = S_RD_STAT;
                   else if (timeoutHit) nextState = S_RD_MASK1;
      default:
        if (busAck) begin
          if (busErr) nextState = S_IDLE;
          else begin
            unique case (state)
              S_RD_CTRL0:  nextState = S_WR_EN;
              S_WR_EN:     nextState = S_WR_CHAN;
              S_WR_CHAN:   nextState = S_SETTLE;
              S_WR_GO:     nextState = S_RD_MASK0;
              S_RD_MASK0:  nextState = S_WR_UNMASK;
              S_WR_UNMASK: nextState = S_WAIT;
              S_RD_STAT:   nextState = S_WR_STAT;
              S_WR_STAT:   nextState = adcStatHit ? S_RD_MASK1 : S_WAIT;
              S_RD_MASK1:  nextState = S_WR_MASK;
              S_WR_MASK:   nextState = S_RD_HI;
              S_RD_HI:     nextState = S_RD_LO;
              S_RD_LO:     nextState = S_RD_CTRL1;
              S_RD_CTRL1:  nextState = S_WR_OFF;
              default:     nextState = S_IDLE;
            endcase
          end
        end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      done        <= 1'b0;
      errFlag     <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      state <= nextState;
      done  <= 1'b0;
      if (state == S_IDLE && startReq) begin
        timeoutFlag <= 1'b0;
        errFlag     <= (chanSel == 2'd0);
        done        <= (chanSel == 2'd0);
      end
      if (busAck && busErr) begin
        errFlag <= 1'b1;
        done    <= 1'b1;
      end else if (busAck && state == S_WR_OFF) begin
        done <= 1'b1;
      end
      if (state == S_WAIT && !devIrq && timeoutHit) timeoutFlag <= 1'b1;
    end
  end

  // R11: completion pulse only with the sequencer idle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R4: start write is requested only after the settle interval elapsed
  assert_settle_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == S_WR_GO) |-> $past(settleDone));
  // R7: timeout flag rises only from an expired wait without interrupt
  assert_timeout_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(timeoutHit && !devIrq));
  // R12: error flag rises from an error response or a rejected channel
  assert_err_src_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ($past(busReady && busErr && busValid) ||
                        $past(state == S_IDLE && startReq && chanSel == 2'd0)));
  // R12: no request follows an error response
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && busErr) |=> !busValid);
endmodule

// File: rtl/thermConvSeq.sv
module thermConvSeq
  import thermSeqPkg::*;
#(
  parameter int unsigned CLK_HZ     = 100000000,
  parameter int unsigned SETTLE_US  = 50,
  parameter int unsigned TIMEOUT_MS = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] chanSel,
  output logic       busy,
  output logic       done,
  output logic [9:0] rawCode,
  output logic       errFlag,
  output logic       timeoutFlag,
  output logic       busValid,
  output logic       busWrite,
  output logic [7:0] busAddr,
  output logic [7:0] busWdata,
  input  logic       busReady,
  input  logic [7:0] busRdata,
  input  logic       busErr,
  input  logic       devIrq
);
  localparam int unsigned SETTLE_CYC  = (CLK_HZ / 1000000) * SETTLE_US;
  localparam int unsigned TIMEOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  dpCtlT ctl;
  logic  settleDone, timeoutHit, adcStatHit;

  thermSeqControl ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .busReady(busReady), .busErr(busErr), .devIrq(devIrq),
    .settleDone(settleDone), .timeoutHit(timeoutHit), .adcStatHit(adcStatHit),
    .ctl(ctl), .busValid(busValid), .busy(busy), .done(done),
    .errFlag(errFlag), .timeoutFlag(timeoutFlag)
  );

  thermSeqDatapath #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chanIn(chanSel),
    .busAck(busValid && busReady), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .busWrite(busWrite),
    .settleDone(settleDone), .timeoutHit(timeoutHit), .adcStatHit(adcStatHit),
    .rawCode(rawCode)
  );

  // R2: a pending request holds its address, direction and data
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) &&
                                 $stable(busWrite) && $stable(busWdata)));
endmodule

// File: tb/thermConvSeq_tb_top.sv
module thermConvSeq_tb_top;
  localparam int SETTLE = 50;
  localparam int TMO    = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [1:0] chanSel = 2'd0;
  logic busy, done, errFlag, timeoutFlag, busValid, busWrite;
  logic [9:0] rawCode;
  logic [7:0] busAddr, busWdata;
  logic busReady = 1'b0;
  logic [7:0] busRdata = 8'h00;
  logic busErr = 1'b0;
  logic devIrq;

  thermConvSeq #(.CLK_HZ(1000000), .SETTLE_US(50), .TIMEOUT_MS(1)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .busy(busy), .done(done), .rawCode(rawCode), .errFlag(errFlag),
    .timeoutFlag(timeoutFlag), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .busErr(busErr), .devIrq(devIrq)
  );

  always #5 clk = ~clk;

  // ---------------- device register model ----------------
  logic [7:0] devRegs [256];
  logic [7:0] cfgCtrl, cfgMask, cfgStat, cfgHi, cfgLo;
  logic [1:0] cfgCh;
  int  cfgIrqDelay = 0, cfgErrAt = -1;
  logic clrLog = 1'b0;
  int  cyc = 0;
  int  logN = 0, holdErrs = 0, irqCnt = 0, lat = 0;
  logic serving = 1'b0;
  logic [7:0] curAddr, curWd;
  logic curWr;
  logic       logWr   [64];
  logic [7:0] logAddr [64];
  logic [7:0] logData [64];
  int         logStart[64];
  int         logAck  [64];

  assign devIrq = |(devRegs[1] & ~devRegs[2]);

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    logic [7:0] st;
    busReady <= 1'b0;
    busErr   <= 1'b0;
    st = devRegs[1];
    if (clrLog) begin
      for (int i = 0; i < 256; i++) devRegs[i] <= 8'h00;
      devRegs[8'h50] <= cfgCtrl;
      devRegs[8'h02] <= cfgMask;
      devRegs[8'h01] <= cfgStat;
      devRegs[8'h54 + 8'(2 * cfgCh)] <= cfgHi;
      devRegs[8'h55 + 8'(2 * cfgCh)] <= cfgLo;
      logN <= 0; holdErrs <= 0; irqCnt <= 0; serving <= 1'b0;
    end else begin
      if (irqCnt > 0) begin
        irqCnt <= irqCnt - 1;
        if (irqCnt == 1) st = st | 8'h04;
      end
      if (busValid && !busReady) begin
        if (!serving) begin
          serving <= 1'b1;
          lat <= $urandom_range(0, 3);
          curAddr <= busAddr; curWd <= busWdata; curWr <= busWrite;
          logStart[logN] <= cyc;
        end else begin
          if (busAddr != curAddr || busWdata != curWd || busWrite != curWr)
            holdErrs <= holdErrs + 1;
          if (lat == 0) begin
            busReady <= 1'b1;
            serving  <= 1'b0;
            if (logN == cfgErrAt) busErr <= 1'b1;
            logWr[logN] <= busWrite;
            logAddr[logN] <= busAddr;
            logAck[logN] <= cyc;
            if (busWrite) begin
              logData[logN] <= busWdata;
              if (busAddr == 8'h01) st = st & ~busWdata;
              else devRegs[busAddr] <= busWdata;
              if (busAddr == 8'h50 && busWdata[0] && cfgIrqDelay > 0)
                irqCnt <= cfgIrqDelay;
            end else begin
              logData[logN] <= devRegs[busAddr];
              busRdata <= devRegs[busAddr];
            end
            logN <= logN + 1;
          end else lat <= lat - 1;
        end
      end
      devRegs[1] <= st;
    end
  end

  // ---------------- checking ----------------
  int checks = 0, failures = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hiAddrOf(logic [1:0] ch);
    case (ch)
      2'd1: return 8'h56;
      2'd2: return 8'h58;
      default: return 8'h5A;
    endcase
  endfunction

  task automatic expTx(int i, logic wr, logic [7:0] addr, logic [7:0] data,
                       logic chkData, string req);
    chk({req, " dir"}, int'(logWr[i]), int'(wr));
    chk({req, " addr"}, int'(logAddr[i]), int'(addr));
    if (chkData) chk({req, " data"}, int'(logData[i]), int'(data));
  endtask

  logic sawDone, busyAfterStart, busyAtDone;

  task automatic runSeq(logic [1:0] ch, logic [7:0] c, logic [7:0] m, logic [7:0] s,
                        logic [7:0] hi, logic [7:0] lo, int irqDelay, int errAt);
    int waitCnt;
    @(negedge clk);
    cfgCtrl = c; cfgMask = m; cfgStat = s; cfgHi = hi; cfgLo = lo;
    cfgCh = (ch == 2'd0) ? 2'd1 : ch;
    cfgIrqDelay = irqDelay; cfgErrAt = errAt;
    clrLog = 1'b1;
    @(negedge clk);
    clrLog = 1'b0;
    startReq = 1'b1; chanSel = ch;
    @(negedge clk);
    startReq = 1'b0;
    busyAfterStart = busy;
    sawDone = done; busyAtDone = busy;
    waitCnt = 0;
    while (!sawDone && waitCnt < 4000) begin
      @(negedge clk);
      waitCnt++;
      if (done) begin sawDone = 1'b1; busyAtDone = busy; end
    end
    chk("R11 done seen", int'(sawDone), 1);
    chk("R11 busy low at done", int'(busyAtDone), 0);
    @(negedge clk);
    chk("R11 done one cycle", int'(done), 0);
  endtask

  task automatic checkFull(logic [1:0] ch, logic [7:0] c, logic [7:0] m,
                           logic [7:0] hi, logic [7:0] lo, logic expTmo);
    int i;
    logic [7:0] run;
    run = c | 8'h21 | {5'd0, ch, 1'b0};
    chk("R2 request held", holdErrs, 0);
    chk("R11 busy after start", int'(busyAfterStart), 1);
    expTx(0, 1'b0, 8'h50, 8'h00, 1'b0, "R3 read ctrl");
    expTx(1, 1'b1, 8'h50, c | 8'h20, 1'b1, "R3 enable");
    expTx(2, 1'b1, 8'h50, c | 8'h20 | {5'd0, ch, 1'b0}, 1'b1, "R3 channel");
    expTx(3, 1'b1, 8'h50, run, 1'b1, "R3 start");
    chk("R4 settle gap ok", int'((logStart[3] - logAck[2]) >= SETTLE), 1);
    expTx(4, 1'b0, 8'h02, 8'h00, 1'b0, "R5 read mask");
    expTx(5, 1'b1, 8'h02, m & 8'hFB, 1'b1, "R5 unmask");
    i = 6;
    while (i < 60 && logAddr[i] == 8'h01) begin
      chk("R6 stat read", int'(logWr[i]), 0);
      expTx(i + 1, 1'b1, 8'h01, logData[i], 1'b1, "R6 stat writeback");
      i += 2;
    end
    if (expTmo) chk("R7 timeout gap ok", int'((logStart[i] - logAck[5]) >= TMO), 1);
    chk("R7 timeout flag", int'(timeoutFlag), int'(expTmo));
    expTx(i, 1'b0, 8'h02, 8'h00, 1'b0, "R8 read mask");
    expTx(i + 1, 1'b1, 8'h02, m | 8'h04, 1'b1, "R8 remask");
    expTx(i + 2, 1'b0, hiAddrOf(ch), 8'h00, 1'b0, "R9 high addr");
    expTx(i + 3, 1'b0, hiAddrOf(ch) + 8'd1, 8'h00, 1'b0, "R9 low addr");
    expTx(i + 4, 1'b0, 8'h50, 8'h00, 1'b0, "R10 read ctrl");
    expTx(i + 5, 1'b1, 8'h50, run & 8'hD9, 1'b1, "R10 power down");
    chk("R10 txn count", logN, i + 6);
    chk("R9 raw code", int'(rawCode), int'({hi[1:0], lo}));
    chk("R12 no error", int'(errFlag), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cfgCtrl = 0; cfgMask = 0; cfgStat = 0; cfgHi = 0; cfgLo = 0; cfgCh = 1;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 busValid", int'(busValid), 0);
    chk("R1 flags", int'({errFlag, timeoutFlag}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // directed: channel 3, fast completion, high byte upper bits must be dropped
    runSeq(2'd3, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hA5, 5, -1);
    checkFull(2'd3, 8'h00, 8'hFF, 8'hFF, 8'hA5, 1'b0);

    // directed: channel 1, a foreign unmasked status bit must not end the wait (R6)
    runSeq(2'd1, 8'hC0, 8'hEB, 8'h10, 8'h02, 8'h3C, 120, -1);
    checkFull(2'd1, 8'hC0, 8'hEB, 8'h02, 8'h3C, 1'b0);
    chk("R6 foreign bit cleared", int'(devRegs[1]), 0);

    // directed: channel 2, never completes -> timeout, still remasks and powers down
    runSeq(2'd2, 8'h91, 8'hFF, 8'h00, 8'h01, 8'h77, 0, -1);
    checkFull(2'd2, 8'h91, 8'hFF, 8'h01, 8'h77, 1'b1);
    chk("R10 ctrl left off", int'(devRegs[8'h50]), int'((8'h91 | 8'h21 | 8'h04) & 8'hD9));

    // directed: error response on the unmask read aborts
    runSeq(2'd2, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 5, 4);
    repeat (20) @(negedge clk);
    chk("R12 error flag", int'(errFlag), 1);
    chk("R12 no further requests", logN, 5);
    chk("R12 bus idle", int'(busValid), 0);

    // directed: channel code 0 rejected without bus traffic
    runSeq(2'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 5, -1);
    repeat (5) @(negedge clk);
    chk("R13 error flag", int'(errFlag), 1);
    chk("R13 no requests", logN, 0);

    // constrained random runs
    for (int k = 0; k < 10; k++) begin
      logic [1:0] ch;
      logic [7:0] c, m, hi, lo;
      ch = 2'($urandom_range(1, 3));
      c  = 8'($urandom_range(0, 255));
      m  = 8'($urandom_range(0, 255)) | 8'h04;
      hi = 8'($urandom_range(0, 255));
      lo = 8'($urandom_range(0, 255));
      runSeq(ch, c, m, 8'h00, hi, lo, $urandom_range(1, 300), -1);
      checkFull(ch, c, m, hi, lo, 1'b0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule